// File: doc/BRIEF.md
# Round-Robin Execution Unit Selector

This block manages one group of interchangeable execution units. Each unit is named by a one-hot bit in an `N_UNITS`-wide mask. A fixed membership mask says which bits belong to the group. The block keeps three pieces of state:

- a ready mask, giving the units that are currently free;
- a rotating candidate mask, giving the units still owed a turn in the current round;
- an early-removal mask, giving the units taken out of the round ahead of their turn.

On a select request the block answers in the same cycle with the one-hot ID of the chosen unit. The choice is the highest set bit of the candidate mask that is also ready. Higher candidates that are not ready are dropped from the round on the way down.

Separate use and release ports mark a unit busy or free. A `busy_all` output tells the enclosing logic that no member unit is free. The enclosing logic may only issue a select request while `busy_all` is low.

Top module: `rr_unit_selector`

## Requirements
- R1: After a synchronous active-high reset, the ready mask and the candidate mask both equal the membership mask, the early-removal mask is empty, `busy_all` is low and `sel_id` is zero.
- R2: While `sel_req` is high, `sel_id` is the one-hot ID of the highest candidate-mask bit that is also ready. Every candidate above it that is not ready is removed from the candidate mask at the clock edge.
- R3: A selection by itself does not take the chosen unit out of the round. Repeated selects with no use in between return the same unit.
- R4: A use request (`use_id` one-hot) clears that unit's ready bit. It also removes the unit from the candidate mask at the clock edge.
- R5: A used unit whose ID is numerically greater than the current highest candidate is recorded as removed early. It is left out of the next refill.
- R6: When the candidate mask becomes empty, it is refilled with the membership mask XOR the early-removal mask, and the early-removal mask is cleared. A refill never yields an empty candidate mask. The refill can happen while a select walks down the round, or after a use.
- R7: A release request (`rel_id` one-hot) sets that unit's ready bit. It does not put the unit back into the current round.
- R8: When a release and a use name the same unit in one cycle, the release is applied first and the use second. The unit ends the cycle busy.
- R9: `busy_all` is high exactly when no member unit is ready.
- R10: `sel_id` is all zeros whenever `sel_req` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_req | input | 1 | Request a unit this cycle |
| sel_id | output | N_UNITS | One-hot ID of the chosen unit, zero when idle |
| use_req | input | 1 | Mark a unit busy |
| use_id | input | N_UNITS | One-hot ID of the unit to mark busy |
| rel_req | input | 1 | Mark a unit free |
| rel_id | input | N_UNITS | One-hot ID of the unit to mark free |
| ready_mask | output | N_UNITS | Units currently free |
| busy_all | output | 1 | No member unit is free |

## Verification
A release and a use can land on the same unit in the same cycle. A release and a use on the same unit are driven together while that unit is busy. The result is judged by the ready mask after the edge: the unit must stay busy, and `busy_all` must stay high. A select and a use can also coincide. The stimulus issues them together on the chosen unit, so that the use empties the candidate mask and forces a refill. The next select must then skip the unit that was removed early. The reverse case is also covered: a select walks down an exhausted round and refills it by itself.

// File: rtl/rr_sel_pkg.sv
package rr_sel_pkg;

    localparam int unsigned MAX_UNITS = 64;

    typedef logic [MAX_UNITS-1:0] umask_t;

    // State of the rotation for one group
    typedef struct packed {
        umask_t cand;
        umask_t early;
    } rot_t;

    // Isolate the most significant set bit of a mask
    function automatic umask_t top_bit(input umask_t m);
        umask_t r;
        r = '0;
        for (int i = 0; i < int'(MAX_UNITS); i++) begin
            if (m[i]) begin
                r = '0;
                r[i] = 1'b1;
            end
        end
        return r;
    endfunction

    // Reload an exhausted round, leaving out early removals
    function automatic rot_t reload(input umask_t member, input rot_t s);
        rot_t r;
        r = s;
        if (s.cand == '0) begin
            r.cand  = member ^ s.early;
            r.early = '0;
        end
        return r;
    endfunction

endpackage

// File: rtl/rr_pick.sv
module rr_pick
    import rr_sel_pkg::*;
#(
    parameter int unsigned N_UNITS = 4
) (
    input  logic [N_UNITS-1:0] member,
    input  logic [N_UNITS-1:0] ready,
    input  logic [N_UNITS-1:0] cand_in,
    input  logic [N_UNITS-1:0] early_in,
    output logic [N_UNITS-1:0] pick,
    output logic [N_UNITS-1:0] cand_out,
    output logic [N_UNITS-1:0] early_out
);
    // Enough steps to drain the round, reload, and drain once more
    localparam int unsigned STEPS = 2 * N_UNITS + 2;

    rot_t   st;
    umask_t hd;
    umask_t rdy_w;
    umask_t mem_w;
    umask_t found_m;
    logic   found;

    always_comb begin
        mem_w    = umask_t'(member);
        rdy_w    = umask_t'(ready);
        st.cand  = umask_t'(cand_in);
        st.early = umask_t'(early_in);
        found    = 1'b0;
        found_m  = '0;
        hd       = '0;
        for (int s = 0; s < int'(STEPS); s++) begin
            if (!found) begin
                st = reload(mem_w, st);
                hd = top_bit(st.cand);
                if ((hd & rdy_w) != '0) begin
                    found   = 1'b1;
                    found_m = hd;
                end else begin
                    st.cand = st.cand & ~hd;
                end
            end
        end
        pick      = found_m[N_UNITS-1:0];
        cand_out  = st.cand[N_UNITS-1:0];
        early_out = st.early[N_UNITS-1:0];
    end

endmodule

// File: rtl/rr_retire.sv
module rr_retire
    import rr_sel_pkg::*;
#(
    parameter int unsigned N_UNITS = 4
) (
    input  logic [N_UNITS-1:0] member,
    input  logic               en,
    input  logic [N_UNITS-1:0] id,
    input  logic [N_UNITS-1:0] cand_in,
    input  logic [N_UNITS-1:0] early_in,
    output logic [N_UNITS-1:0] cand_out,
    output logic [N_UNITS-1:0] early_out
);
    rot_t   st;
    umask_t hd;
    umask_t id_w;

    always_comb begin
        st.cand  = umask_t'(cand_in);
        st.early = umask_t'(early_in);
        id_w     = umask_t'(id & member);
        hd       = top_bit(st.cand);
        if (en && id_w != '0) begin
            if (id_w > hd) begin
                st.early = st.early | id_w;
            end
            st.cand = st.cand & ~id_w;
            st = reload(umask_t'(member), st);
        end
        cand_out  = st.cand[N_UNITS-1:0];
        early_out = st.early[N_UNITS-1:0];
    end

endmodule

// File: rtl/rr_ready_upd.sv
module rr_ready_upd #(
    parameter int unsigned N_UNITS = 4
) (
    input  logic [N_UNITS-1:0] member,
    input  logic [N_UNITS-1:0] ready_in,
    input  logic               rel_en,
    input  logic [N_UNITS-1:0] rel_id,
    input  logic               use_en,
    input  logic [N_UNITS-1:0] use_id,
    output logic [N_UNITS-1:0] ready_out
);
    logic [N_UNITS-1:0] after_rel;

    // Release first, then use
    always_comb begin
        after_rel = ready_in | (rel_en ? (rel_id & member) : '0);
        ready_out = after_rel & ~(use_en ? use_id : '0);
    end

endmodule

// File: rtl/rr_unit_selector.sv
module rr_unit_selector #(
    parameter int unsigned          N_UNITS = 4,
    parameter logic [N_UNITS-1:0]   MEMBER  = '1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               sel_req,
    output logic [N_UNITS-1:0] sel_id,
    input  logic               use_req,
    input  logic [N_UNITS-1:0] use_id,
    input  logic               rel_req,
    input  logic [N_UNITS-1:0] rel_id,
    output logic [N_UNITS-1:0] ready_mask,
    output logic               busy_all
);
    logic [N_UNITS-1:0] ready_q, cand_q, early_q;
    logic [N_UNITS-1:0] pick_w, pcand_w, pearly_w;
    logic [N_UNITS-1:0] scand_w, searly_w;
    logic [N_UNITS-1:0] ncand_w, nearly_w, nready_w;

    rr_pick #(.N_UNITS(N_UNITS)) u_pick (
        .member   (MEMBER),
        .ready    (ready_q),
        .cand_in  (cand_q),
        .early_in (early_q),
        .pick     (pick_w),
        .cand_out (pcand_w),
        .early_out(pearly_w)
    );

    // A select only advances the round when it is requested
    always_comb begin
        scand_w  = sel_req ? pcand_w  : cand_q;
        searly_w = sel_req ? pearly_w : early_q;
    end

    rr_retire #(.N_UNITS(N_UNITS)) u_retire (
        .member   (MEMBER),
        .en       (use_req),
        .id       (use_id),
        .cand_in  (scand_w),
        .early_in (searly_w),
        .cand_out (ncand_w),
        .early_out(nearly_w)
    );

    rr_ready_upd #(.N_UNITS(N_UNITS)) u_ready (
        .member   (MEMBER),
        .ready_in (ready_q),
        .rel_en   (rel_req),
        .rel_id   (rel_id),
        .use_en   (use_req),
        .use_id   (use_id),
        .ready_out(nready_w)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ready_q <= MEMBER;
            cand_q  <= MEMBER;
            early_q <= '0;
        end else begin
            ready_q <= nready_w;
            cand_q  <= ncand_w;
            early_q <= nearly_w;
        end
    end

    assign sel_id     = sel_req ? pick_w : '0;
    assign ready_mask = ready_q;
    assign busy_all   = ((ready_q & MEMBER) == '0);

endmodule

// File: rtl/rr_unit_selector_chk.sv
module rr_unit_selector_chk #(
    parameter int unsigned        N_UNITS = 4,
    parameter logic [N_UNITS-1:0] MEMBER  = '1
) (
    input logic               clk,
    input logic               rst,
    input logic               sel_req,
    input logic [N_UNITS-1:0] sel_id,
    input logic               use_req,
    input logic [N_UNITS-1:0] use_id,
    input logic               rel_req,
    input logic [N_UNITS-1:0] rel_id,
    input logic [N_UNITS-1:0] ready_mask,
    input logic               busy_all,
    input logic [N_UNITS-1:0] cand_q,
    input logic [N_UNITS-1:0] early_q
);
    AST_SEL_ONEHOT_READY: assert property (@(posedge clk) disable iff (rst)
        sel_req |-> ($onehot(sel_id) && ((sel_id & ready_mask) != '0))); // R2
    AST_SEL_ONLY_WHEN_FREE: assert property (@(posedge clk) disable iff (rst)
        sel_req |-> !busy_all); // R2
    AST_SEL_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
        !sel_req |-> (sel_id == '0)); // R10
    AST_USE_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        use_req |-> $onehot(use_id)); // R4
    AST_USE_ON_FREE_UNIT: assert property (@(posedge clk) disable iff (rst)
        use_req |-> (((ready_mask | (rel_req ? rel_id : '0)) & use_id) != '0)); // R4
    AST_USE_CLEARS: assert property (@(posedge clk) disable iff (rst)
        use_req |=> ((ready_mask & $past(use_id)) == '0)); // R4
    AST_REL_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        rel_req |-> $onehot(rel_id)); // R7
    AST_REL_SETS: assert property (@(posedge clk) disable iff (rst)
        (rel_req && !(use_req && (use_id == rel_id)))
        |=> ((ready_mask & $past(rel_id & MEMBER)) == $past(rel_id & MEMBER))); // R7
    AST_CAND_NONEMPTY: assert property (@(posedge clk) disable iff (rst)
        (cand_q != '0)); // R6
    AST_EARLY_NOT_ALL: assert property (@(posedge clk) disable iff (rst)
        (early_q != MEMBER)); // R6
endmodule

bind rr_unit_selector rr_unit_selector_chk #(
    .N_UNITS(N_UNITS),
    .MEMBER (MEMBER)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .sel_req   (sel_req),
    .sel_id    (sel_id),
    .use_req   (use_req),
    .use_id    (use_id),
    .rel_req   (rel_req),
    .rel_id    (rel_id),
    .ready_mask(ready_mask),
    .busy_all  (busy_all),
    .cand_q    (cand_q),
    .early_q   (early_q)
);

// File: tb/rr_unit_selector_bench.sv
module rr_unit_selector_bench;
    localparam int unsigned N = 4;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         sel_req = 1'b0;
    logic [N-1:0] sel_id;
    logic         use_req = 1'b0;
    logic [N-1:0] use_id = '0;
    logic         rel_req = 1'b0;
    logic [N-1:0] rel_id = '0;
    logic [N-1:0] ready_mask;
    logic         busy_all;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    rr_unit_selector #(.N_UNITS(N)) u_rr_unit_selector (
        .clk(clk), .rst(rst), .sel_req(sel_req), .sel_id(sel_id),
        .use_req(use_req), .use_id(use_id), .rel_req(rel_req), .rel_id(rel_id),
        .ready_mask(ready_mask), .busy_all(busy_all)
    );

    // Row: {sel, use, use_id, rel, rel_id, exp_sel, exp_ready, exp_busy_all}
    localparam int NV = 21;
    localparam logic [19:0] TBL [0:NV-1] = '{
        {1'b1,1'b1,4'b1000,1'b0,4'b0000, 4'b1000,4'b0111,1'b0}, // R2 R4
        {1'b1,1'b1,4'b0100,1'b0,4'b0000, 4'b0100,4'b0011,1'b0},
        {1'b1,1'b1,4'b0010,1'b0,4'b0000, 4'b0010,4'b0001,1'b0},
        {1'b1,1'b1,4'b0001,1'b0,4'b0000, 4'b0001,4'b0000,1'b1}, // R9 R6
        {1'b0,1'b0,4'b0000,1'b1,4'b0100, 4'b0000,4'b0100,1'b0}, // R7 R10
        {1'b1,1'b0,4'b0000,1'b0,4'b0000, 4'b0100,4'b0100,1'b0}, // R2 skip busy top
        {1'b0,1'b0,4'b0000,1'b1,4'b1000, 4'b0000,4'b1100,1'b0},
        {1'b1,1'b0,4'b0000,1'b0,4'b0000, 4'b0100,4'b1100,1'b0}, // R3 R7
        {1'b0,1'b1,4'b1000,1'b0,4'b0000, 4'b0000,4'b0100,1'b0}, // R5
        {1'b0,1'b1,4'b0100,1'b0,4'b0000, 4'b0000,4'b0000,1'b1},
        {1'b0,1'b0,4'b0000,1'b1,4'b0001, 4'b0000,4'b0001,1'b0},
        {1'b0,1'b0,4'b0000,1'b1,4'b1000, 4'b0000,4'b1001,1'b0},
        {1'b1,1'b1,4'b0001,1'b0,4'b0000, 4'b0001,4'b1000,1'b0}, // R6
        {1'b0,1'b0,4'b0000,1'b1,4'b0100, 4'b0000,4'b1100,1'b0},
        {1'b1,1'b0,4'b0000,1'b0,4'b0000, 4'b0100,4'b1100,1'b0}, // R5 exclusion
        {1'b1,1'b1,4'b0100,1'b0,4'b0000, 4'b0100,4'b1000,1'b0},
        {1'b1,1'b0,4'b0000,1'b0,4'b0000, 4'b1000,4'b1000,1'b0}, // R6 reload in select
        {1'b0,1'b1,4'b1000,1'b0,4'b0000, 4'b0000,4'b0000,1'b1},
        {1'b0,1'b1,4'b1000,1'b1,4'b1000, 4'b0000,4'b0000,1'b1}, // R8
        {1'b0,1'b0,4'b0000,1'b1,4'b0010, 4'b0000,4'b0010,1'b0},
        {1'b1,1'b0,4'b0000,1'b0,4'b0000, 4'b0010,4'b0010,1'b0}
    };

    task automatic check(input string req, input string what,
                         input logic [N-1:0] act, input logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        for (int c = 0; c < 5000; c++) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R1: reset state
        check("R1", "ready_mask", ready_mask, 4'b1111);
        check("R1", "busy_all", {3'b000, busy_all}, 4'b0000);
        check("R1", "sel_id", sel_id, 4'b0000);

        for (int i = 0; i < NV; i++) begin
            sel_req = TBL[i][19];
            use_req = TBL[i][18];
            use_id  = TBL[i][17:14];
            rel_req = TBL[i][13];
            rel_id  = TBL[i][12:9];
            #1;
            // R2 R10: same-cycle selection result
            check(TBL[i][19] ? "R2" : "R10", "sel_id", sel_id, TBL[i][8:5]);
            @(posedge clk);
            @(negedge clk);
            // R4 R7 R8: ready mask after the edge
            check(i == 18 ? "R8" : "R4/R7", "ready_mask", ready_mask, TBL[i][4:1]);
            // R9: all-busy flag
            check("R9", "busy_all", {3'b000, busy_all}, {3'b000, TBL[i][0]});
            sel_req = 1'b0; use_req = 1'b0; rel_req = 1'b0;
            use_id = '0; rel_id = '0;
        end

        // R1: reset mid-run restores ready and candidate masks
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        check("R1", "ready_mask after reset", ready_mask, 4'b1111);
        check("R1", "busy_all after reset", {3'b000, busy_all}, 4'b0000);
        sel_req = 1'b1;
        #1;
        check("R1", "sel_id from refilled candidates", sel_id, 4'b1000);
        @(posedge clk);
        @(negedge clk);
        sel_req = 1'b0;
        #1;
        check("R10", "sel_id idle", sel_id, 4'b0000);

        done = 1'b1;
        finish_run();
    end

endmodule